// File: doc/BRIEF.md
# Footer-relative event interrupt generator

This block drives the active-low interrupt line that a MAC-PHY presents to its SPI host. It watches a small set of internal readiness conditions (receive chunks waiting, transmit credits free, extended status event pending). It compares each one against the value that the most recent data footer sent to the host reported for it. A condition that was reported absent and has since become true pulls the line low. When a condition was already reported present, the host knows about it, so the condition raises nothing.

The line clears on traffic, not on a register access. The next data header from the host releases it. The header also disarms every source, so a source can fire again only after a footer has told the host that it is absent. After an extended status event the host is expected to read status register 0 to learn the cause. The SPI shifter and the status registers sit outside this block. The shifter supplies a strobe with the three reported values for every footer it sends, and a strobe for every data header it receives.

Top module: `mpirq_gen`

## Requirements
- R1: The condition vector `cond_i` carries receive-chunks-available in bit 0. When that source is armed and bit 0 is high at a rising clock edge, `irq_no` is low after that edge.
- R2: Bit 1 of `cond_i` (transmit credits free) raises the interrupt in the same way when its source is armed.
- R3: Bit 2 of `cond_i` (extended status event, after which the host reads status register 0) raises the interrupt in the same way when its source is armed.
- R4: A footer strobe loads the arm bits as the inverse of `ftr_val_i`, which uses the same bit encoding as `cond_i`. A source whose footer value was 1 cannot raise the interrupt, even when its condition is high.
- R5: Once low, `irq_no` stays low until a header strobe. A header strobe makes `irq_no` high after that edge.
- R6: When a header strobe and a firing condition meet in the same cycle, the clear wins and `irq_no` stays high.
- R7: A header strobe disarms all sources. A condition that stays high after the clear does not re-raise the interrupt until a footer reports that source as absent.
- R8: Reset holds `irq_no` high and arms every source. A condition that is present when reset is released raises the interrupt at the first edge.
- R9: When a footer strobe and a header strobe arrive in the same cycle, the arm bits are taken from the footer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | NUM_SRC | Live conditions: bit0 rx chunks, bit1 tx credits, bit2 extended status |
| ftr_sent_i | input | 1 | One-cycle strobe, footer sent to host |
| ftr_val_i | input | NUM_SRC | Condition values reported in that footer |
| hdr_rcvd_i | input | 1 | One-cycle strobe, data header received from host |
| irq_no | output | 1 | Interrupt to host, active low, registered |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it. A cause is a condition meeting an armed source, a header clearing the line, or a footer or reset changing the arm bits. A footer's effect on the arm bits therefore shows only in the cycle after the footer. The driver applies each input vector at a falling edge and queues the value of `irq_no` that the requirements predict for the following edge. The monitor samples 2 ns after every rising edge and compares against the head of the queue. Each comparison is therefore pinned to the single edge at which the registered line must have moved.

// File: rtl/mpirq_pkg.sv
package mpirq_pkg;
  localparam int unsigned SRC_RX      = 0;
  localparam int unsigned SRC_TX      = 1;
  localparam int unsigned SRC_EXT     = 2;
  localparam int unsigned NUM_SRC_DEF = 3;
endpackage

// File: rtl/mpirq_arm_bank.sv
module mpirq_arm_bank #(
  parameter int unsigned NUM_SRC = mpirq_pkg::NUM_SRC_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ftr_sent_i,
  input  logic [NUM_SRC-1:0] ftr_val_i,
  input  logic               hdr_rcvd_i,
  output logic [NUM_SRC-1:0] arm_o
);
  // per source: armed while the last footer reported it absent
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_arm
    logic arm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          arm_q <= 1'b1;
      else if (ftr_sent_i)  arm_q <= ~ftr_val_i[g];
      else if (hdr_rcvd_i)  arm_q <= 1'b0;
    end
    assign arm_o[g] = arm_q;
  end

  assert_ftr_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ftr_sent_i |=> (arm_o == ~$past(ftr_val_i)));
  assert_hdr_disarm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_rcvd_i && !ftr_sent_i) |=> (arm_o == '0));
  assert_arm_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hdr_rcvd_i && !ftr_sent_i) |=> $stable(arm_o));
endmodule

// File: rtl/mpirq_detect.sv
module mpirq_detect #(
  parameter int unsigned NUM_SRC = mpirq_pkg::NUM_SRC_DEF
) (
  input  logic [NUM_SRC-1:0] arm_i,
  input  logic [NUM_SRC-1:0] cond_i,
  output logic [NUM_SRC-1:0] cause_o,
  output logic               fire_o
);
  always_comb begin
    cause_o = arm_i & cond_i;
    fire_o  = |cause_o;
  end
endmodule

// File: rtl/mpirq_line.sv
module mpirq_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic hdr_rcvd_i,
  output logic irq_no
);
  logic irq_q;

  // header clear has priority over a new cause
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         irq_q <= 1'b0;
    else if (hdr_rcvd_i) irq_q <= 1'b0;
    else if (fire_i)     irq_q <= 1'b1;
  end

  assign irq_no = ~irq_q;

  assert_hdr_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_rcvd_i |=> irq_no);
  assert_clear_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_rcvd_i && fire_i) |=> irq_no);
  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !hdr_rcvd_i) |=> !irq_no);
endmodule

// File: rtl/mpirq_gen.sv
module mpirq_gen #(
  parameter int unsigned NUM_SRC = mpirq_pkg::NUM_SRC_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] cond_i,
  input  logic               ftr_sent_i,
  input  logic [NUM_SRC-1:0] ftr_val_i,
  input  logic               hdr_rcvd_i,
  output logic               irq_no
);
  logic [NUM_SRC-1:0] arm;
  logic [NUM_SRC-1:0] cause;
  logic               fire;

  mpirq_arm_bank #(.NUM_SRC(NUM_SRC)) u_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ftr_sent_i(ftr_sent_i),
    .ftr_val_i (ftr_val_i),
    .hdr_rcvd_i(hdr_rcvd_i),
    .arm_o     (arm)
  );

  mpirq_detect #(.NUM_SRC(NUM_SRC)) u_det (
    .arm_i  (arm),
    .cond_i (cond_i),
    .cause_o(cause),
    .fire_o (fire)
  );

  mpirq_line u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .hdr_rcvd_i(hdr_rcvd_i),
    .irq_no    (irq_no)
  );

  // R1 R2 R3: a falling line needs an armed, present condition one cycle earlier
  assert_fall_has_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> ($past(cause) != '0));
  assert_cause_raises_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause != '0) && !hdr_rcvd_i) |=> !irq_no);
  assert_cause_armed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause & ~arm) == '0));
endmodule

// File: tb/sim_mpirq_gen.sv
module sim_mpirq_gen;
  localparam int unsigned N = 3;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] cond_i = '0;
  logic         ftr_sent_i = 1'b0;
  logic [N-1:0] ftr_val_i = '0;
  logic         hdr_rcvd_i = 1'b0;
  logic         irq_no;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk_i = ~clk_i;

  mpirq_gen #(.NUM_SRC(N)) u0 (
    .clk_i, .rst_ni, .cond_i, .ftr_sent_i, .ftr_val_i, .hdr_rcvd_i, .irq_no
  );

  // monitor: result due one edge after the driven vector
  always @(posedge clk_i) begin
    #2;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (irq_no !== it.exp) begin
        errors++;
        $display("FAIL %s: irq_no=%b expected %b", it.tag, irq_no, it.exp);
      end
    end
  end

  task automatic step(input logic [N-1:0] c, input logic f, input logic [N-1:0] fv,
                      input logic h, input logic exp, input string tag);
    cond_i     = c;
    ftr_sent_i = f;
    ftr_val_i  = fv;
    hdr_rcvd_i = h;
    sb_q.push_back('{exp, tag});
    @(negedge clk_i);
  endtask

  task automatic check_now(input logic exp, input string tag);
    checks++;
    if (irq_no !== exp) begin
      errors++;
      $display("FAIL %s: irq_no=%b expected %b", tag, irq_no, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check_now(1'b1, "R8 reset level");
    rst_ni = 1'b1;
    step(3'b000, 0, 3'b000, 0, 1'b1, "R8 idle after reset");
    step(3'b001, 0, 3'b000, 0, 1'b0, "R1 rx armed by reset");
    step(3'b001, 0, 3'b000, 0, 1'b0, "R5 line held");
    step(3'b001, 0, 3'b000, 1, 1'b1, "R5 header clears");
    step(3'b001, 0, 3'b000, 0, 1'b1, "R7 disarmed after header");
    step(3'b001, 1, 3'b000, 0, 1'b1, "R7 footer edge uses old arms");
    step(3'b001, 0, 3'b000, 0, 1'b0, "R7 rearmed by absent footer");
    step(3'b001, 0, 3'b000, 1, 1'b1, "R5 header clears again");
    step(3'b001, 1, 3'b001, 0, 1'b1, "R4 footer reports rx present");
    step(3'b001, 0, 3'b000, 0, 1'b1, "R4 reported source silent");
    step(3'b011, 0, 3'b000, 0, 1'b0, "R2 tx credits raise");
    step(3'b000, 1, 3'b000, 1, 1'b1, "R9 footer and header together");
    step(3'b100, 0, 3'b000, 0, 1'b0, "R9 arms from footer, R3 ext raises");
    step(3'b100, 0, 3'b000, 1, 1'b1, "R5 header clears ext");
    step(3'b000, 1, 3'b000, 0, 1'b1, "R4 absent footer rearms");
    step(3'b010, 0, 3'b000, 1, 1'b1, "R6 clear wins over cause");
    step(3'b010, 0, 3'b000, 0, 1'b1, "R6 no late raise");
    step(3'b010, 1, 3'b011, 0, 1'b1, "R4 footer reports rx tx present");
    step(3'b011, 0, 3'b000, 0, 1'b1, "R4 reported sources silent");
    step(3'b111, 0, 3'b000, 0, 1'b0, "R3 ext raises alone");
    // second reset with a condition already present
    cond_i = 3'b001;
    rst_ni = 1'b0;
    @(negedge clk_i);
    check_now(1'b1, "R8 reset forces line high");
    rst_ni = 1'b1;
    step(3'b001, 0, 3'b000, 0, 1'b0, "R8 present condition raises");
    step(3'b000, 0, 3'b000, 1, 1'b1, "R5 final clear");
    @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule